// File: doc/BRIEF.md
# Weighted Fair Queueing Link Scheduler

This block decides which of several flows sends the next packet on a shared output link. It approximates fluid weighted sharing by giving every arriving packet a virtual finish tag. The link is then granted to the packets in increasing tag order. Packet payloads are stored elsewhere. The scheduler keeps only a short queue of (length, finish tag) pairs for each flow, the finish tag of each flow's most recent arrival, and one system virtual clock.

An arrival carries a flow number and a length. The start tag depends on the flow's state. A flow that already has queued work starts from its own last finish tag. A flow that was idle starts from the current virtual time. The finish tag is the start tag plus the length divided by the flow's weight. Tags are fixed point with 12 fractional bits.

The virtual clock advances once per cycle while any flow is backlogged. Each step is 1.0 divided by the sum of the backlogged weights. When the link is ready, the block issues a single-cycle grant for the head packet with the smallest tag and removes that packet from its queue. The downstream link holds `link_ready` low while it transmits, so a grant is never interrupted.

Top module: `wfq_sched`

## Requirements
- R1: An accepted arrival of length L on flow i gets finish tag S + floor(L*4096 / w), where w is the flow's 8-bit weight taken from `weights[8*i +: 8]`. A weight of 0 is treated as 1.
- R2: If the flow already holds at least one queued packet when the arrival comes, S is the finish tag of that flow's previous arrival.
- R3: If the flow holds no queued packet when the arrival comes, S is the value of `vtime` in the arrival cycle.
- R4: When `link_ready` is high and some flow is backlogged, `grant_valid` is high in the same cycle. `grant_flow`, `grant_len` and `grant_tag` then describe the head packet whose tag is the smallest among all flow heads.
- R5: If head tags are equal, the grant goes to the lowest flow number.
- R6: At each clock edge where at least one flow is backlogged, `vtime` increases by floor(4096 / Wb), where Wb is the sum of the backlogged flows' weights.
- R7: While no flow is backlogged, `vtime` holds its value and `grant_valid` stays low.
- R8: No grant is issued while `link_ready` is low. Each grant removes exactly one packet, the granted one, and packets of a flow leave in arrival order.
- R9: Each flow queues at most 4 packets. An arrival to a full flow is dropped and leaves that flow's queue unchanged.
- R10: After reset all queues are empty, `vtime` is 0 and `grant_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| weights | input | NFLOW*WW | Packed per-flow weights, flow i at bits [8*i +: 8] |
| arr_valid | input | 1 | Packet arrival strobe |
| arr_flow | input | log2(NFLOW) | Flow of the arriving packet |
| arr_len | input | LW | Length of the arriving packet |
| link_ready | input | 1 | Link idle and able to accept a packet this cycle |
| grant_valid | output | 1 | A packet is granted this cycle |
| grant_flow | output | log2(NFLOW) | Flow of the granted packet |
| grant_len | output | LW | Length of the granted packet |
| grant_tag | output | TW | Virtual finish tag of the granted packet |
| vtime | output | TW | Current system virtual time |

## Verification
Several properties are checked on every cycle by assertions:
- the granted tag never exceeds any backlogged head tag;
- the virtual clock holds when nothing is queued and never goes backwards while work is queued;
- grants happen only with the link ready, and at most one queue is popped per cycle;
- queue occupancy stays within its depth.

Other behaviour can only be shown by the bench scenarios, each checked against hand-computed values:
- the exact tag arithmetic, including fixed-point truncation;
- which start tag is chosen, backlogged versus idle restart;
- the exact virtual time step for a given set of weights;
- the tie-break on equal tags;
- dropping arrivals to a full queue.

// File: rtl/wfq_sched.sv
`timescale 1ns/1ps
module wfq_sched #(
  parameter int NFLOW = 4,
  parameter int WW    = 8,
  parameter int LW    = 12,
  parameter int TW    = 32,
  parameter int FRAC  = 12,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NFLOW*WW-1:0]        weights,
  input  logic                       arr_valid,
  input  logic [$clog2(NFLOW)-1:0]   arr_flow,
  input  logic [LW-1:0]              arr_len,
  input  logic                       link_ready,
  output logic                       grant_valid,
  output logic [$clog2(NFLOW)-1:0]   grant_flow,
  output logic [LW-1:0]              grant_len,
  output logic [TW-1:0]              grant_tag,
  output logic [TW-1:0]              vtime
);
  localparam int FW = $clog2(NFLOW);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = LW + FRAC;
  localparam logic [TW-1:0] ONE = TW'(1) << FRAC;

  logic [LW-1:0] len_q [NFLOW][DEPTH];
  logic [TW-1:0] tag_q [NFLOW][DEPTH];
  logic [PW-1:0] rd_p [NFLOW];
  logic [PW-1:0] wr_p [NFLOW];
  logic [CW-1:0] cnt [NFLOW];
  logic [TW-1:0] last_fin [NFLOW];
  logic [TW-1:0] head_tag [NFLOW];
  logic [TW-1:0] vt_q;

  logic [NFLOW-1:0] bk, push, pop;
  logic [NFLOW*TW-1:0] head_flat;
  logic [NFLOW*CW-1:0] cnt_flat;
  logic [WW-1:0] w_sel;
  logic [SW-1:0] quo;
  logic [TW-1:0] fin_tag, wsum, vinc, best_tag;
  logic [FW-1:0] best;

  function automatic logic [WW-1:0] weff(input logic [WW-1:0] w);
    return (w == '0) ? WW'(1) : w;
  endfunction

  always_comb begin
    wsum = '0;
    for (int i = 0; i < NFLOW; i++) begin
      bk[i] = cnt[i] != '0;
      head_tag[i] = tag_q[i][rd_p[i]];
      head_flat[i*TW +: TW] = head_tag[i];
      cnt_flat[i*CW +: CW] = cnt[i];
      if (bk[i]) wsum = wsum + TW'(weff(weights[i*WW +: WW]));
    end
  end

  assign vinc = ONE / ((wsum == '0) ? TW'(1) : wsum);

  assign w_sel   = weff(weights[arr_flow*WW +: WW]);
  assign quo     = {arr_len, {FRAC{1'b0}}} / SW'(w_sel);
  assign fin_tag = (bk[arr_flow] ? last_fin[arr_flow] : vt_q) + TW'(quo);

  always_comb begin
    push = '0;
    if (arr_valid && cnt[arr_flow] != CW'(DEPTH)) push[arr_flow] = 1'b1;
  end

  always_comb begin
    logic found;
    found = 1'b0;
    best = '0;
    best_tag = '0;
    for (int i = 0; i < NFLOW; i++) begin
      if (bk[i] && (!found || head_tag[i] < best_tag)) begin
        found = 1'b1;
        best = FW'(i);
        best_tag = head_tag[i];
      end
    end
  end

  assign grant_valid = link_ready && (bk != '0);
  assign grant_flow  = best;
  assign grant_tag   = best_tag;
  assign grant_len   = len_q[best][rd_p[best]];
  assign vtime       = vt_q;

  always_comb begin
    pop = '0;
    if (grant_valid) pop[best] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NFLOW; i++) begin
      if (push[i]) begin
        len_q[i][wr_p[i]] <= arr_len;
        tag_q[i][wr_p[i]] <= fin_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vt_q <= '0;
      for (int i = 0; i < NFLOW; i++) begin
        rd_p[i] <= '0;
        wr_p[i] <= '0;
        cnt[i] <= '0;
        last_fin[i] <= '0;
      end
    end else begin
      if (bk != '0) vt_q <= vt_q + vinc;
      for (int i = 0; i < NFLOW; i++) begin
        if (push[i]) begin
          wr_p[i] <= wr_p[i] + 1'b1;
          last_fin[i] <= fin_tag;
        end
        if (pop[i]) rd_p[i] <= rd_p[i] + 1'b1;
        if (push[i] && !pop[i]) cnt[i] <= cnt[i] + 1'b1;
        else if (!push[i] && pop[i]) cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wfq_sched_chk.sv
`timescale 1ns/1ps
module wfq_sched_chk #(
  parameter int NFLOW = 4,
  parameter int TW    = 32,
  parameter int CW    = 3,
  parameter int DEPTH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                link_ready,
  input logic                grant_valid,
  input logic [TW-1:0]       grant_tag,
  input logic [TW-1:0]       vtime,
  input logic [NFLOW-1:0]    bk,
  input logic [NFLOW-1:0]    pop,
  input logic [NFLOW*TW-1:0] head_flat,
  input logic [NFLOW*CW-1:0] cnt_flat
);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk == '0) |=> $stable(vtime));
  // R7
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk == '0) |-> !grant_valid);
  // R6
  vt_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk != '0) |=> vtime >= $past(vtime));
  // R8
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != '0) |-> link_ready && $onehot0(pop));

  for (genvar i = 0; i < NFLOW; i++) begin : g_flow
    // R4
    min_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && bk[i]) |-> grant_tag <= head_flat[i*TW +: TW]);
    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind wfq_sched wfq_sched_chk #(.NFLOW(NFLOW), .TW(TW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_ready(link_ready), .grant_valid(grant_valid),
  .grant_tag(grant_tag), .vtime(vtime), .bk(bk), .pop(pop),
  .head_flat(head_flat), .cnt_flat(cnt_flat)
);

// File: tb/tb_wfq_sched.sv
`timescale 1ns/1ps
module tb_wfq_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] weights = {8'd8, 8'd4, 8'd2, 8'd1};
  logic arr_valid = 1'b0;
  logic [1:0] arr_flow = '0;
  logic [11:0] arr_len = '0;
  logic link_ready = 1'b0;
  logic grant_valid;
  logic [1:0] grant_flow;
  logic [11:0] grant_len;
  logic [31:0] grant_tag, vtime;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  wfq_sched dut (.clk(clk), .rst_n(rst_n), .weights(weights), .arr_valid(arr_valid),
    .arr_flow(arr_flow), .arr_len(arr_len), .link_ready(link_ready),
    .grant_valid(grant_valid), .grant_flow(grant_flow), .grant_len(grant_len),
    .grant_tag(grant_tag), .vtime(vtime));

  // {arr_valid, flow, len, link_ready, exp_valid, exp_flow, exp_tag}
  localparam int VW = 1 + 2 + 12 + 1 + 1 + 2 + 32;
  localparam int NV = 9;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'd0, 12'd4, 1'b0, 1'b0, 2'd0, 32'd0},
    {1'b1, 2'd1, 12'd4, 1'b0, 1'b0, 2'd0, 32'd0},
    {1'b1, 2'd2, 12'd4, 1'b0, 1'b0, 2'd0, 32'd0},
    {1'b1, 2'd3, 12'd8, 1'b0, 1'b0, 2'd0, 32'd0},
    {1'b0, 2'd0, 12'd0, 1'b1, 1'b1, 2'd1, 32'd8192},
    {1'b0, 2'd0, 12'd0, 1'b1, 1'b1, 2'd2, 32'd8192},
    {1'b0, 2'd0, 12'd0, 1'b1, 1'b1, 2'd3, 32'd9557},
    {1'b0, 2'd0, 12'd0, 1'b1, 1'b1, 2'd0, 32'd16384},
    {1'b0, 2'd0, 12'd0, 1'b1, 1'b0, 2'd0, 32'd0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] f, input logic [11:0] l, input bit rdy);
    @(negedge clk);
    arr_valid = v; arr_flow = f; arr_len = l; link_ready = rdy;
    #1;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] va, vb, t1, t2;
    repeat (3) @(negedge clk);
    link_ready = 1'b1;
    #1;
    // R10
    chk(grant_valid == 1'b0, "R10 grant after reset", grant_valid, 0);
    chk(vtime == 0, "R10 vtime after reset", vtime, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R4 R5 R8: idle-start tags, minimum-tag order, tie 8192 to flow 1
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] e;
      e = VEC[k];
      drive(e[50], e[49:48], e[47:36], e[35]);
      chk(grant_valid == e[34], "R8 grant valid", grant_valid, e[34]);
      if (e[34]) begin
        chk(grant_flow == e[33:32], "R4 R5 grant flow", grant_flow, e[33:32]);
        chk(grant_tag == e[31:0], "R1 grant tag", grant_tag, e[31:0]);
      end
    end

    // R7: idle hold
    va = vtime;
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);
    chk(vtime == va, "R7 vtime held", vtime, va);
    chk(grant_valid == 1'b0, "R7 no grant idle", grant_valid, 0);

    // R3 then R2 on flow 1 (w=2)
    drive(1, 1, 12'd2, 0);
    t1 = vtime + 32'd4096;
    drive(1, 1, 12'd6, 0);
    t2 = t1 + 32'd12288;
    drive(0, 0, 0, 1);
    chk(grant_valid && grant_flow == 1 && grant_tag == t1, "R3 idle start tag", grant_tag, t1);
    chk(grant_len == 12'd2, "R8 fifo order len", grant_len, 2);
    drive(0, 0, 0, 1);
    chk(grant_valid && grant_tag == t2, "R2 backlogged start tag", grant_tag, t2);
    drive(0, 0, 0, 1);
    chk(grant_valid == 1'b0, "R8 single pop per grant", grant_valid, 0);

    // R3 restart uses vtime, not old finish
    drive(1, 1, 12'd2, 0);
    t1 = vtime + 32'd4096;
    drive(0, 0, 0, 1);
    chk(grant_tag == t1, "R3 restart after idle", grant_tag, t1);

    // R6: step with flow2 alone (w=4) then flows 0 and 2 (w=5)
    drive(1, 2, 12'd4, 0);
    drive(0, 0, 0, 0);
    va = vtime;
    drive(1, 0, 12'd1, 0);
    vb = vtime;
    chk(vb - va == 32'd1024, "R6 step w=4", vb - va, 1024);
    drive(0, 0, 0, 0);
    va = vtime;
    drive(0, 0, 0, 0);
    vb = vtime;
    chk(vb - va == 32'd819, "R6 step w=5", vb - va, 819);
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    chk(grant_valid == 1'b0, "R8 no grant without ready", grant_valid, 0);

    // R9: fifth arrival to flow 3 dropped
    for (int k = 1; k <= 5; k++) drive(1, 3, 12'(k), 0);
    for (int k = 1; k <= 4; k++) begin
      drive(0, 0, 0, 1);
      chk(grant_valid && grant_flow == 3 && grant_len == 12'(k), "R9 queued len", grant_len, k);
    end
    drive(0, 0, 0, 1);
    chk(grant_valid == 1'b0, "R9 overflow dropped", grant_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule